// File: doc/BRIEF.md
# Double-Rate Segment Multiplexer

The block takes a 32-bit word from a front-end source once per base clock period, along with a separate valid bit for each 16-bit half. It splits that word into two 16-bit segments and delivers them one after the other, at twice the base rate, to the parallel input of a serializer. Each segment leaves with its own valid bit and with a frame flag. The flag tells the far end whether the segment is the first or the second half of the original word.

The source word and its two valid bits go into a 34-bit capture register on the rising edge of the base clock. The output side runs on a double-rate strobe that the serializer provides. It needs no clock of its own. On each strobe edge the block samples the level of the base clock. A high level means a new word was captured at the most recent base rising edge, so the block emits the low half with flag 0. A low level means it emits the high half with flag 1. This phase recovery needs exactly two strobe edges in each base period: one in the high phase of the base clock and one in the low phase.

Top module: `dfmux_top`

## Requirements
- R1: While rst_ni is low, seg_data_o is all zero, seg_vld_o is 0 and seg_flag_o is 0, whatever the inputs are.
- R2: At a strobe edge where the base clock is high, the output takes the low half (data_lo_i as captured) and seg_flag_o is 0.
- R3: At a strobe edge where the base clock is low, the output takes the high half (data_hi_i as captured) and seg_flag_o is 1.
- R4: seg_vld_o carries vld_lo_i with the low segment and vld_hi_i with the high segment. Each valid bit is captured with its own data half, independently of the other.
- R5: Inputs are captured only at the rising edge of clk_base_i. A change to the inputs after that edge has no effect on either segment of the word already captured.
- R6: While the base clock runs, seg_flag_o changes value on every strobe edge after reset.
- R7: The two segments of a word captured at a base rising edge appear on the next two strobe edges, low half first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_base_i | input | 1 | Base clock of the source; it also serves as the phase reference |
| clk_strb_i | input | 1 | Double-rate strobe from the serializer; clocks the output register |
| rst_ni | input | 1 | Active-low asynchronous reset |
| data_hi_i | input | 16 | Upper half of the source word |
| data_lo_i | input | 16 | Lower half of the source word |
| vld_hi_i | input | 1 | Valid bit for the upper half |
| vld_lo_i | input | 1 | Valid bit for the lower half |
| seg_data_o | output | 16 | Current 16-bit segment |
| seg_vld_o | output | 1 | Valid bit of the current segment |
| seg_flag_o | output | 1 | 0 for the first (low) segment, 1 for the second (high) segment |

## Verification
The bench drives the two halves with distinct patterns, including all-ones against all-zeros. A design that swaps the halves, or ties the flag to the wrong phase of the base clock, therefore shows the wrong data next to the flag. It tries all four combinations of the two valid bits, which exposes a design that routes one valid bit to both segments. It also changes the inputs just after the base capture edge, so that a design reading the live inputs at the strobe, rather than the captured word, puts the new value into the high segment. Long runs of words check that the flag toggles on every strobe edge. A phase tracker that locked onto the wrong edge would repeat a segment.

// File: rtl/dfmux_pkg.sv
package dfmux_pkg;

  typedef enum logic {
    HALF_FIRST  = 1'b0,
    HALF_SECOND = 1'b1
  } half_e;

  function automatic logic half_flag(half_e h);
    return (h == HALF_SECOND);
  endfunction

endpackage

// File: rtl/dfmux_cap.sv
// Base-domain capture register: one {valid, data} slice per half.
module dfmux_cap #(
  parameter int SEG_W = 16,
  localparam int SLICE_W = SEG_W + 1,
  localparam int CAP_W = 2 * SLICE_W
) (
  input  logic               clk_base_i,
  input  logic               rst_ni,
  input  logic [SEG_W-1:0]   data_lo_i,
  input  logic [SEG_W-1:0]   data_hi_i,
  input  logic               vld_lo_i,
  input  logic               vld_hi_i,
  output logic [CAP_W-1:0]   cap_o
);

  logic [1:0][SLICE_W-1:0] slice_d;
  logic [1:0][SLICE_W-1:0] slice_q;

  assign slice_d[0] = {vld_lo_i, data_lo_i};
  assign slice_d[1] = {vld_hi_i, data_hi_i};

  for (genvar g = 0; g < 2; g++) begin : g_slice
    always_ff @(posedge clk_base_i or negedge rst_ni) begin
      if (!rst_ni) slice_q[g] <= '0;
      else         slice_q[g] <= slice_d[g];
    end
  end

  assign cap_o = slice_q;

endmodule

// File: rtl/dfmux_phase.sv
// Recovers segment phase from the base clock level seen at the strobe edge.
module dfmux_phase
  import dfmux_pkg::*;
#(
  parameter bit LOW_FIRST = 1'b1
) (
  input  logic  clk_base_i,
  output half_e half_o,
  output logic  sel_hi_o
);

  // High base level: a fresh word was captured this period.
  assign half_o = clk_base_i ? HALF_FIRST : HALF_SECOND;

  if (LOW_FIRST) begin : g_low_first
    assign sel_hi_o = (half_o == HALF_SECOND);
  end else begin : g_high_first
    assign sel_hi_o = (half_o == HALF_FIRST);
  end

endmodule

// File: rtl/dfmux_out.sv
// 2:1 segment selection and strobe-domain output register.
module dfmux_out
  import dfmux_pkg::*;
#(
  parameter int SEG_W = 16,
  localparam int SLICE_W = SEG_W + 1,
  localparam int CAP_W = 2 * SLICE_W
) (
  input  logic              clk_strb_i,
  input  logic              rst_ni,
  input  logic [CAP_W-1:0]  cap_i,
  input  half_e             half_i,
  input  logic              sel_hi_i,
  output logic [SEG_W-1:0]  seg_data_o,
  output logic              seg_vld_o,
  output logic              seg_flag_o
);

  logic [SLICE_W-1:0] slice_sel;
  logic [SLICE_W-1:0] slice_q;
  logic               flag_q;

  assign slice_sel = sel_hi_i ? cap_i[CAP_W-1:SLICE_W] : cap_i[SLICE_W-1:0];

  always_ff @(posedge clk_strb_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slice_q <= '0;
      flag_q  <= 1'b0;
    end else begin
      slice_q <= slice_sel;
      flag_q  <= half_flag(half_i);
    end
  end

  assign seg_data_o = slice_q[SEG_W-1:0];
  assign seg_vld_o  = slice_q[SEG_W];
  assign seg_flag_o = flag_q;

endmodule

// File: rtl/dfmux_top.sv
module dfmux_top
  import dfmux_pkg::*;
#(
  parameter int SEG_W = 16,
  parameter bit LOW_FIRST = 1'b1,
  localparam int CAP_W = 2 * (SEG_W + 1)
) (
  input  logic             clk_base_i,
  input  logic             clk_strb_i,
  input  logic             rst_ni,
  input  logic [SEG_W-1:0] data_hi_i,
  input  logic [SEG_W-1:0] data_lo_i,
  input  logic             vld_hi_i,
  input  logic             vld_lo_i,
  output logic [SEG_W-1:0] seg_data_o,
  output logic             seg_vld_o,
  output logic             seg_flag_o
);

  logic [CAP_W-1:0] cap_q;
  half_e            half;
  logic             sel_hi;

  dfmux_cap #(.SEG_W(SEG_W)) u_cap (
    .clk_base_i (clk_base_i),
    .rst_ni     (rst_ni),
    .data_lo_i  (data_lo_i),
    .data_hi_i  (data_hi_i),
    .vld_lo_i   (vld_lo_i),
    .vld_hi_i   (vld_hi_i),
    .cap_o      (cap_q)
  );

  dfmux_phase #(.LOW_FIRST(LOW_FIRST)) u_phase (
    .clk_base_i (clk_base_i),
    .half_o     (half),
    .sel_hi_o   (sel_hi)
  );

  dfmux_out #(.SEG_W(SEG_W)) u_out (
    .clk_strb_i (clk_strb_i),
    .rst_ni     (rst_ni),
    .cap_i      (cap_q),
    .half_i     (half),
    .sel_hi_i   (sel_hi),
    .seg_data_o (seg_data_o),
    .seg_vld_o  (seg_vld_o),
    .seg_flag_o (seg_flag_o)
  );

endmodule

// File: rtl/dfmux_chk.sv
module dfmux_chk #(
  parameter int SEG_W = 16,
  parameter bit LOW_FIRST = 1'b1,
  localparam int SLICE_W = SEG_W + 1,
  localparam int CAP_W = 2 * SLICE_W
) (
  input logic             clk_strb_i,
  input logic             clk_base_i,
  input logic             rst_ni,
  input logic [CAP_W-1:0] cap_q,
  input logic [SEG_W-1:0] seg_data_o,
  input logic             seg_vld_o,
  input logic             seg_flag_o
);

  logic [SLICE_W-1:0] lo_slice, hi_slice, first_slice, second_slice;
  logic [1:0]         edges_q;

  assign lo_slice     = cap_q[SLICE_W-1:0];
  assign hi_slice     = cap_q[CAP_W-1:SLICE_W];
  assign first_slice  = LOW_FIRST ? lo_slice : hi_slice;
  assign second_slice = LOW_FIRST ? hi_slice : lo_slice;

  always_ff @(posedge clk_strb_i or negedge rst_ni) begin
    if (!rst_ni)              edges_q <= '0;
    else if (edges_q != 2'd2) edges_q <= edges_q + 2'd1;
  end

  // R2 R4 R7
  first_seg_chk: assert property (@(posedge clk_strb_i) disable iff (!rst_ni)
    clk_base_i |=> (!seg_flag_o && {seg_vld_o, seg_data_o} == $past(first_slice)));

  // R3 R4
  second_seg_chk: assert property (@(posedge clk_strb_i) disable iff (!rst_ni)
    !clk_base_i |=> (seg_flag_o && {seg_vld_o, seg_data_o} == $past(second_slice)));

  // R6
  flag_toggle_chk: assert property (@(posedge clk_strb_i) disable iff (!rst_ni)
    (edges_q == 2'd2) |-> (seg_flag_o != $past(seg_flag_o)));

  // R5
  cap_hold_chk: assert property (@(posedge clk_strb_i) disable iff (!rst_ni)
    (edges_q == 2'd2 && !clk_base_i) |-> $stable(cap_q));

endmodule

bind dfmux_top dfmux_chk #(.SEG_W(SEG_W), .LOW_FIRST(LOW_FIRST)) u_chk (
  .clk_strb_i (clk_strb_i),
  .clk_base_i (clk_base_i),
  .rst_ni     (rst_ni),
  .cap_q      (cap_q),
  .seg_data_o (seg_data_o),
  .seg_vld_o  (seg_vld_o),
  .seg_flag_o (seg_flag_o)
);

// File: tb/dfmux_top_tb_top.sv
`timescale 1ns/1ps
module dfmux_top_tb_top;

  logic        clk_strb = 1'b0;
  logic        clk_base = 1'b0;
  logic        rst_n    = 1'b0;
  logic [15:0] data_hi  = '0;
  logic [15:0] data_lo  = '0;
  logic        vld_hi   = 1'b0;
  logic        vld_lo   = 1'b0;
  logic [15:0] seg_data;
  logic        seg_vld;
  logic        seg_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  // Strobe: 250 MHz, rising at 4k+2 ns.
  always #2 clk_strb = ~clk_strb;

  // Base: half rate, rising at 8n+1 ns.
  initial begin
    #1;
    forever begin
      clk_base = 1'b1; #4;
      clk_base = 1'b0; #4;
    end
  end

  dfmux_top dut_i (
    .clk_base_i (clk_base),
    .clk_strb_i (clk_strb),
    .rst_ni     (rst_n),
    .data_hi_i  (data_hi),
    .data_lo_i  (data_lo),
    .vld_hi_i   (vld_hi),
    .vld_lo_i   (vld_lo),
    .seg_data_o (seg_data),
    .seg_vld_o  (seg_vld),
    .seg_flag_o (seg_flag)
  );

  task automatic chk(string req, logic [17:0] act, logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic set_in(logic [15:0] h, logic [15:0] l, logic vh, logic vl);
    data_hi = h; data_lo = l; vld_hi = vh; vld_lo = vl;
  endtask

  // Send one word, check both segments away from the strobe edge.
  task automatic send_word(string req, logic [15:0] h, logic [15:0] l,
                           logic vh, logic vl);
    @(negedge clk_base);
    set_in(h, l, vh, vl);
    @(posedge clk_base);
    @(posedge clk_strb); #2;
    chk({req, " first"}, {seg_flag, seg_vld, seg_data}, {1'b0, vl, l});
    @(posedge clk_strb); #2;
    chk({req, " second"}, {seg_flag, seg_vld, seg_data}, {1'b1, vh, h});
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    set_in(16'hFFFF, 16'hA5A5, 1'b1, 1'b1);
    repeat (3) @(posedge clk_strb);
    #1;
    chk("R1 in reset", {seg_flag, seg_vld, seg_data}, 18'h0);
    @(posedge clk_strb); #1;
    chk("R1 in reset later", {seg_flag, seg_vld, seg_data}, 18'h0);
    @(negedge clk_base); #2;
    rst_n = 1'b1;
  endtask

  task automatic t_basic();
    send_word("R2 R3 R7 distinct", 16'h1234, 16'hABCD, 1'b1, 1'b1);
    send_word("R2 R3 ones/zeros", 16'hFFFF, 16'h0000, 1'b1, 1'b1);
    send_word("R2 R3 zeros/ones", 16'h0000, 16'hFFFF, 1'b1, 1'b1);
  endtask

  task automatic t_valid();
    send_word("R4 vh0 vl0", 16'h0F0F, 16'hF0F0, 1'b0, 1'b0);
    send_word("R4 vh1 vl0", 16'h1111, 16'h2222, 1'b1, 1'b0);
    send_word("R4 vh0 vl1", 16'h3333, 16'h4444, 1'b0, 1'b1);
    send_word("R4 vh1 vl1", 16'h5555, 16'h6666, 1'b1, 1'b1);
  endtask

  task automatic t_hold();
    @(negedge clk_base);
    set_in(16'hBEEF, 16'hCAFE, 1'b1, 1'b0);
    @(posedge clk_base); #0.5;
    set_in(16'h0000, 16'h0000, 1'b0, 1'b1);
    @(posedge clk_strb); #2;
    chk("R5 first after change", {seg_flag, seg_vld, seg_data}, {1'b0, 1'b0, 16'hCAFE});
    @(posedge clk_strb); #2;
    chk("R5 second after change", {seg_flag, seg_vld, seg_data}, {1'b1, 1'b1, 16'hBEEF});
  endtask

  task automatic t_toggle();
    logic prev;
    @(negedge clk_base);
    set_in(16'h7777, 16'h8888, 1'b1, 1'b1);
    @(posedge clk_strb); #2;
    prev = seg_flag;
    for (int i = 0; i < 12; i++) begin
      @(posedge clk_strb); #2;
      chk("R6 flag toggles", {17'h0, seg_flag}, {17'h0, ~prev});
      prev = seg_flag;
    end
  endtask

  task automatic t_stream();
    for (int i = 0; i < 8; i++) begin
      logic [15:0] h = 16'(i * 16'h1357 + 16'h0101);
      logic [15:0] l = ~h;
      send_word("R7 stream", h, l, i[0], i[1]);
    end
  endtask

  initial begin
    t_reset();
    t_basic();
    t_valid();
    t_hold();
    t_toggle();
    t_stream();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog act=timeout exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule